// File: doc/BRIEF.md
# Video Memory Write and Prefetch Port

This block gives a host processor byte-wide access to a word-organised video memory. The host loads a 15-bit word address and then streams bytes through two lane strobes: one for the even (low) byte of the word and one for the odd (high) byte. A configuration write sets three things:
- the step the address advances by,
- which of the two lanes advances it,
- an optional remap that rotates the low address bits so that linear host transfers land in a tile-graphics layout.

Reads are served from a one-word prefetch buffer. The buffer is refilled from memory, through the same remap, every time the address is loaded and every time it advances. A read therefore returns the word fetched before that read's own advance.

A gate driven by the display timing drops writes during active display unless blanking is forced. A dropped write on the triggering lane still moves the address, so a host that does not know its writes were refused keeps its position in the stream. The memory array is a plain byte-enabled RAM. By default it is sized smaller than the address space and indexed by the low address bits.

Top module: `vram_port`

## Requirements
- R1: After reset the address is 0, the step is 1, remapping is off, the low lane is the trigger, and both the prefetch buffer and `rd_data` are 0.
- R2: A low-lane write stores `wr_byte` into bits 7:0 of the addressed word. A high-lane write stores it into bits 15:8. The other byte of the word is unchanged.
- R3: `cfg_step` selects the advance step: 0 gives 1 word, 1 gives 32 words, and 2 or 3 give 128 words.
- R4: With `cfg_trig_hi`=0, only low-lane accesses (read or write) advance the address. With `cfg_trig_hi`=1, only high-lane accesses do. An access on the other lane leaves the address unchanged.
- R5: `cfg_remap` 0 uses the address as it is. Values 1, 2 and 3 use a mask M of 0xFF, 0x1FF or 0x3FF and a shift S of 5, 6 or 7, with C=(M+1)/8. The memory word used is then (a & ~M) + (r >> S) + ((r & (C-1)) << 3), where r = a & M.
- R6: A write is discarded when `block_en`=1, `force_blank`=0 and `vcount` < `vis_height`+1. The write proceeds when `vcount` equals `vis_height`+1 or when `force_blank`=1.
- R7: A discarded write on the triggering lane still advances the address. A discarded write on the other lane does not.
- R8: The prefetch buffer is reloaded from the remapped current word after every address load and after every advance. The memory contents used include any write made by the access that caused the advance.
- R9: A low-lane read returns bits 7:0 of the buffer on `rd_data` one cycle later, and a high-lane read returns bits 15:8. The value is the buffer contents from before any reload that the read itself triggers.
- R10: The address wraps from 0x7FFF to 0 when it advances.
- R11: At most one operation is taken per cycle, in the order address load, low write, high write, low read, high read. Any lower-ranked strobe asserted in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_wr | input | 1 | Load the word address from `addr_in` |
| addr_in | input | 15 | New word address |
| cfg_wr | input | 1 | Load the step, remap and trigger configuration |
| cfg_step | input | 2 | Advance step select |
| cfg_remap | input | 2 | Remap mode select |
| cfg_trig_hi | input | 1 | 1: the high lane advances the address; 0: the low lane does |
| wr_lo | input | 1 | Write `wr_byte` to the low byte of the current word |
| wr_hi | input | 1 | Write `wr_byte` to the high byte of the current word |
| wr_byte | input | 8 | Write data |
| rd_lo | input | 1 | Read the low byte of the prefetch buffer |
| rd_hi | input | 1 | Read the high byte of the prefetch buffer |
| block_en | input | 1 | Enable the active-display write gate |
| force_blank | input | 1 | Forced blanking; opens the gate |
| vcount | input | 9 | Current line number |
| vis_height | input | 9 | Visible height in lines |
| rd_data | output | 8 | Registered read data |

## Verification
The bench steps the gate through `vcount` = `vis_height` and `vis_height`+1, and through forced blanking. An off-by-one in the comparison would drop or accept a write one line early or late.

It also issues dropped writes on both lanes. A design that forgets to advance on a dropped trigger write would put every later byte one word short.

A design that refills the buffer before serving a read would return the next word instead of the old one. The bench catches this by reading right after an advance.

Remap modes are checked against the mask, shift and count formula, and the wrap at 0x7FFF is checked by writing there and then reading word 0. A wrong rotation width or a missing wrap would put data at the wrong word.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

  localparam int STEP_SMALL = 1;
  localparam int STEP_MID   = 32;
  localparam int STEP_BIG   = 128;

  typedef struct packed {
    logic [1:0] step;
    logic [1:0] remap;
    logic       trig_hi;
  } port_cfg_t;

  function automatic int unsigned step_words(input logic [1:0] sel);
    case (sel)
      2'd0:    return STEP_SMALL;
      2'd1:    return STEP_MID;
      default: return STEP_BIG;
    endcase
  endfunction

endpackage

// File: rtl/vram_addr_ctl.sv
module vram_addr_ctl
  import vram_port_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              cfg_wr,
  input  port_cfg_t         cfg_in,
  input  logic              acc_lo,
  input  logic              acc_hi,
  output logic [ADDR_W-1:0] addr_q,
  output port_cfg_t         cfg_q,
  output logic              fetch_q
);

  logic adv;

  // Only the lane chosen as trigger moves the address.
  assign adv = cfg_q.trig_hi ? acc_hi : acc_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      cfg_q   <= '0;
      fetch_q <= 1'b0;
    end else begin
      fetch_q <= ld | adv;
      if (ld)
        addr_q <= ld_addr;
      else if (adv)
        addr_q <= addr_q + ADDR_W'(step_words(cfg_q.step));
      if (cfg_wr)
        cfg_q <= cfg_in;
    end
  end

endmodule

// File: rtl/vram_remap.sv
module vram_remap #(
  parameter int ADDR_W = 15
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] xaddr
);

  logic [ADDR_W-1:0] cand [4];

  assign cand[0] = addr;

  // Mode m rotates the low (7+m) bits left by three places.
  for (genvar m = 1; m < 4; m++) begin : g_mode
    localparam int RW = 7 + m;
    assign cand[m] = {addr[ADDR_W-1:RW], addr[RW-4:0], addr[RW-1:RW-3]};
  end

  assign xaddr = cand[mode];

endmodule

// File: rtl/vram_ram.sv
module vram_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [7:0]    wbyte,
  output logic [15:0]   dout
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_lo [DEPTH];
  logic [7:0] mem_hi [DEPTH];

  always_ff @(posedge clk) begin
    if (we_lo) mem_lo[addr] <= wbyte;
    dout[7:0] <= mem_lo[addr];
  end

  always_ff @(posedge clk) begin
    if (we_hi) mem_hi[addr] <= wbyte;
    dout[15:8] <= mem_hi[addr];
  end

endmodule

// File: rtl/vram_port.sv
module vram_port
  import vram_port_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int MEM_AW = 11,
  parameter int VC_W   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_step,
  input  logic [1:0]        cfg_remap,
  input  logic              cfg_trig_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [7:0]        wr_byte,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic              block_en,
  input  logic              force_blank,
  input  logic [VC_W-1:0]   vcount,
  input  logic [VC_W-1:0]   vis_height,
  output logic [7:0]        rd_data
);

  port_cfg_t         cfg_in, cfg_q;
  logic [ADDR_W-1:0] addr_q, xaddr;
  logic [1:0]        step_q;
  logic              fetch_q, fetch_d;
  logic [15:0]       ram_dout, buf_q;
  logic              g_wlo, g_whi, g_rlo, g_rhi;
  logic              blocked, we_lo, we_hi;

  // One operation per cycle, fixed ranking.
  assign g_wlo = !addr_wr && wr_lo;
  assign g_whi = !addr_wr && !wr_lo && wr_hi;
  assign g_rlo = !addr_wr && !wr_lo && !wr_hi && rd_lo;
  assign g_rhi = !addr_wr && !wr_lo && !wr_hi && !rd_lo && rd_hi;

  assign blocked = block_en && !force_blank &&
                   ({1'b0, vcount} < ({1'b0, vis_height} + (VC_W+1)'(1)));
  assign we_lo = g_wlo && !blocked;
  assign we_hi = g_whi && !blocked;

  assign cfg_in = '{step: cfg_step, remap: cfg_remap, trig_hi: cfg_trig_hi};
  assign step_q = cfg_q.step;

  vram_addr_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .ld      (addr_wr),
    .ld_addr (addr_in),
    .cfg_wr  (cfg_wr),
    .cfg_in  (cfg_in),
    .acc_lo  (g_wlo || g_rlo),
    .acc_hi  (g_whi || g_rhi),
    .addr_q  (addr_q),
    .cfg_q   (cfg_q),
    .fetch_q (fetch_q)
  );

  vram_remap #(.ADDR_W(ADDR_W)) u_remap (
    .mode  (cfg_q.remap),
    .addr  (addr_q),
    .xaddr (xaddr)
  );

  vram_ram #(.AW(MEM_AW)) u_ram (
    .clk   (clk),
    .addr  (xaddr[MEM_AW-1:0]),
    .we_lo (we_lo),
    .we_hi (we_hi),
    .wbyte (wr_byte),
    .dout  (ram_dout)
  );

  // Fetch request -> RAM read cycle -> buffer load.
  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_d <= 1'b0;
      buf_q   <= '0;
      rd_data <= '0;
    end else begin
      fetch_d <= fetch_q;
      if (fetch_d)
        buf_q <= ram_dout;
      if (g_rlo)
        rd_data <= buf_q[7:0];
      else if (g_rhi)
        rd_data <= buf_q[15:8];
    end
  end

endmodule

// File: rtl/vram_port_chk.sv
module vram_port_chk
  import vram_port_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int VC_W   = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_wr,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic              rd_lo,
  input logic              block_en,
  input logic              force_blank,
  input logic [VC_W-1:0]   vcount,
  input logic [VC_W-1:0]   vis_height,
  input logic [ADDR_W-1:0] addr_q,
  input logic [1:0]        step_q,
  input logic              trig_hi_q,
  input logic              fetch_q,
  input logic [15:0]       buf_q,
  input logic              we_lo,
  input logic              we_hi,
  input logic [7:0]        rd_data
);

  AST_RESET_RDATA: assert property (@(posedge clk)
    rst |=> rd_data == 8'h00); // R1

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!addr_wr && wr_lo && !trig_hi_q) |=>
      addr_q == ADDR_W'($past(addr_q) + ADDR_W'(step_words($past(step_q))))); // R3

  AST_OTHER_LANE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!addr_wr && wr_lo && trig_hi_q) |=> $stable(addr_q)); // R4

  AST_BLOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (block_en && !force_blank &&
     ({1'b0, vcount} < ({1'b0, vis_height} + (VC_W+1)'(1)))) |-> (!we_lo && !we_hi)); // R6

  AST_LOAD_FETCHES: assert property (@(posedge clk) disable iff (rst)
    addr_wr |=> fetch_q); // R8

  AST_READ_OLD_BUFFER: assert property (@(posedge clk) disable iff (rst)
    (!addr_wr && !wr_lo && !wr_hi && rd_lo) |=> rd_data == $past(buf_q[7:0])); // R9

  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (rst)
    !(we_lo && we_hi)); // R11

endmodule

bind vram_port vram_port_chk #(.ADDR_W(ADDR_W), .VC_W(VC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr_wr     (addr_wr),
  .wr_lo       (wr_lo),
  .wr_hi       (wr_hi),
  .rd_lo       (rd_lo),
  .block_en    (block_en),
  .force_blank (force_blank),
  .vcount      (vcount),
  .vis_height  (vis_height),
  .addr_q      (addr_q),
  .step_q      (step_q),
  .trig_hi_q   (cfg_q.trig_hi),
  .fetch_q     (fetch_q),
  .buf_q       (buf_q),
  .we_lo       (we_lo),
  .we_hi       (we_hi),
  .rd_data     (rd_data)
);

// File: tb/tb_vram_port.sv
module tb_vram_port;

  localparam int MEMW = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_wr = 0, cfg_wr = 0, cfg_trig_hi = 0;
  logic [14:0] addr_in = '0;
  logic [1:0]  cfg_step = '0, cfg_remap = '0;
  logic        wr_lo = 0, wr_hi = 0, rd_lo = 0, rd_hi = 0;
  logic [7:0]  wr_byte = '0;
  logic        block_en = 0, force_blank = 0;
  logic [8:0]  vcount = '0, vis_height = 9'd224;
  logic [7:0]  rd_data;

  always #2.5 clk = ~clk;

  vram_port dut (
    .clk(clk), .rst(rst), .addr_wr(addr_wr), .addr_in(addr_in),
    .cfg_wr(cfg_wr), .cfg_step(cfg_step), .cfg_remap(cfg_remap),
    .cfg_trig_hi(cfg_trig_hi), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_byte(wr_byte), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .block_en(block_en), .force_blank(force_blank),
    .vcount(vcount), .vis_height(vis_height), .rd_data(rd_data)
  );

  // Behavioural reference state.
  int          m_addr, m_step, m_remap, m_trig;
  logic [15:0] m_mem [MEMW];
  logic [15:0] m_buf;
  logic [7:0]  m_rd;
  int          total = 0, bad = 0;
  string       cur_req = "R1";
  bit          done = 0;

  function automatic int xl(int a, int mode);
    int mask, sh, cnt, rem;
    if (mode == 0) return a;
    mask = (mode == 1) ? 'hFF : (mode == 2) ? 'h1FF : 'h3FF;
    sh   = mode + 4;
    cnt  = (mask + 1) / 8;
    rem  = a & mask;
    return (a & ~mask & 'h7FFF) + (rem >> sh) + ((rem & (cnt - 1)) << 3);
  endfunction

  function automatic int widx(int a);
    return xl(a, m_remap) % MEMW;
  endfunction

  function automatic bit m_blocked();
    return block_en && !force_blank && (int'(vcount) < int'(vis_height) + 1);
  endfunction

  function automatic void m_advance();
    m_addr = (m_addr + m_step) & 'h7FFF;
    m_buf  = m_mem[widx(m_addr)];
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the reference.
  always @(negedge clk)
    if (!rst && !done) check(cur_req, rd_data, m_rd);

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic op_load(int a, int gap = 3);
    addr_wr = 1; addr_in = 15'(a);
    @(posedge clk);
    m_addr = a; m_buf = m_mem[widx(a)];
    @(negedge clk); addr_wr = 0;
    idle(gap);
  endtask

  task automatic op_cfg(int st, int rm, int tr);
    cfg_wr = 1; cfg_step = 2'(st); cfg_remap = 2'(rm); cfg_trig_hi = tr[0];
    @(posedge clk);
    m_step = (st == 0) ? 1 : (st == 1) ? 32 : 128; m_remap = rm; m_trig = tr;
    @(negedge clk); cfg_wr = 0;
    idle(1);
  endtask

  task automatic op_wr(int lane, int b, int gap = 3);
    int i;
    if (lane) wr_hi = 1; else wr_lo = 1;
    wr_byte = 8'(b);
    @(posedge clk);
    i = widx(m_addr);
    if (!m_blocked()) begin
      if (lane) m_mem[i][15:8] = 8'(b); else m_mem[i][7:0] = 8'(b);
    end
    if (lane == m_trig) m_advance();
    @(negedge clk); wr_lo = 0; wr_hi = 0;
    idle(gap);
  endtask

  task automatic op_rd(int lane, int gap = 3);
    if (lane) rd_hi = 1; else rd_lo = 1;
    @(posedge clk);
    m_rd = lane ? m_buf[15:8] : m_buf[7:0];
    if (lane == m_trig) m_advance();
    @(negedge clk); rd_lo = 0; rd_hi = 0;
    idle(gap);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_addr = 0; m_step = 1; m_remap = 0; m_trig = 0; m_buf = '0; m_rd = '0;
    for (int k = 0; k < MEMW; k++) m_mem[k] = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: reset state; high lane is not the trigger, so no advance.
    check("R1", rd_data, 0);
    op_rd(1);
    check("R1", rd_data, 0);

    // Fill memory (R2 lanes) with step 1, high lane trigger.
    cur_req = "R2";
    op_cfg(0, 0, 1);
    op_load(0, 0);
    for (int k = 0; k < MEMW; k++) begin
      op_wr(0, (k * 7 + 3) & 'hFF, 0);
      op_wr(1, (k >> 3) ^ 'h5A, 0);
    end
    idle(3);
    op_load('h10);
    op_rd(0); check("R2", rd_data, 'h73);
    op_rd(1); check("R2", rd_data, 'h58);
    op_load('h20); op_wr(0, 'h9C); op_load('h20);
    op_rd(0); check("R2", rd_data, 'h9C);
    op_rd(1); check("R2", rd_data, 'h5E);

    // R3: step sizes with low-lane trigger.
    cur_req = "R3";
    op_cfg(1, 0, 0);
    op_load('h40);
    op_wr(0, 'hAA);
    op_wr(0, 'hBB);
    op_cfg(2, 0, 0);
    op_wr(0, 'hCC);
    op_cfg(3, 0, 0);
    op_wr(0, 'hDD);
    op_cfg(0, 0, 1);
    op_load('h60);  op_rd(0); check("R3", rd_data, 'hBB);
    op_load('h80);  op_rd(0); check("R3", rd_data, 'hCC);
    op_load('h100); op_rd(0); check("R3", rd_data, 'hDD);

    // R4: non-trigger lane keeps the address.
    cur_req = "R4";
    op_load('h30);
    op_wr(0, 'h11);
    op_wr(0, 'h22);
    op_wr(1, 'h33);
    op_load('h30); op_rd(0); check("R4", rd_data, 'h22);
    op_rd(1); check("R4", rd_data, 'h33);
    op_rd(0); check("R4", rd_data, m_mem['h31][7:0]);

    // R5: remap modes.
    cur_req = "R5";
    op_cfg(0, 1, 1);
    op_load('h21); op_wr(0, 'hE1); op_wr(1, 'hE2);
    op_cfg(0, 0, 1);
    op_load('h09); op_rd(0); check("R5", rd_data, 'hE1);
    op_rd(1); check("R5", rd_data, 'hE2);
    for (int md = 1; md < 4; md++) begin
      op_cfg(0, md, 1);
      op_load('h208 + md * 3);
      op_wr(0, 'h40 + md); op_wr(1, 'h50 + md);
      op_load('h208 + md * 3);
      op_rd(0); op_rd(1);
    end
    op_cfg(0, 3, 1);
    op_load('h208); op_wr(0, 'h77);
    op_cfg(0, 0, 1);
    op_load('h44); op_rd(0); check("R5", rd_data, 'h77);

    // R6 / R7: active-display gate.
    cur_req = "R6";
    block_en = 1; force_blank = 0; vis_height = 9'd224;
    op_load('h50);
    vcount = 9'd10;  op_wr(0, 'hF0);
    vcount = 9'd224; op_wr(0, 'hF1);
    vcount = 9'd225; op_wr(0, 'hF2);
    vcount = 9'd10; force_blank = 1; op_wr(1, 'hF3);
    force_blank = 0;
    op_load('h50); op_rd(0); check("R6", rd_data, 'hF2);
    op_rd(1); check("R6", rd_data, 'hF3);
    cur_req = "R7";
    op_load('h58);
    op_wr(1, 'hA5);
    op_wr(0, 'hB6);
    block_en = 0;
    op_wr(0, 'hC7); op_wr(1, 'hD8);
    op_load('h59); op_rd(0); check("R7", rd_data, 'hC7);
    op_rd(1); check("R7", rd_data, 'hD8);
    op_load('h58); op_rd(1); check("R7", rd_data, m_mem['h58][15:8]);

    // R8 / R9: reload timing and old-buffer reads.
    cur_req = "R9";
    op_load('h70);
    op_rd(0); check("R9", rd_data, m_mem['h70][7:0]);
    op_rd(1); check("R9", rd_data, m_mem['h70][15:8]);
    op_rd(1); check("R9", rd_data, m_mem['h71][15:8]);
    cur_req = "R8";
    op_load('h90);
    op_wr(0, 'h12); op_wr(1, 'h34);
    op_load('h90);
    op_wr(1, 'h56);
    op_rd(0); check("R8", rd_data, m_mem['h91][7:0]);

    // R10: wrap at the top of the address space.
    cur_req = "R10";
    op_load('h7FFF);
    op_wr(0, 'h01); op_wr(1, 'h02);
    op_wr(0, 'h03); op_wr(1, 'h04);
    op_load(0); op_rd(0); check("R10", rd_data, 'h03);
    op_rd(1); check("R10", rd_data, 'h04);

    // R11: simultaneous strobes; only the highest-ranked one is taken.
    cur_req = "R11";
    op_load('hA0);
    wr_lo = 1; wr_hi = 1; wr_byte = 8'h6B;
    @(posedge clk);
    m_mem[widx(m_addr)][7:0] = 8'h6B;
    @(negedge clk); wr_lo = 0; wr_hi = 0;
    idle(3);
    op_load('hA0); op_rd(0); check("R11", rd_data, 'h6B);
    op_rd(1); check("R11", rd_data, m_mem['hA0][15:8]);
    addr_wr = 1; addr_in = 15'h00B0; wr_lo = 1; wr_byte = 8'hEE;
    @(posedge clk);
    m_addr = 'hB0; m_buf = m_mem[widx('hB0)];
    @(negedge clk); addr_wr = 0; wr_lo = 0;
    idle(3);
    op_rd(0); check("R11", rd_data, m_mem['hB0][7:0]);

    idle(4);
    finish_run();
  end

endmodule